// File: doc/BRIEF.md
# Time-of-Flight Range Controller

This block runs a single distance measurement each time a start request arrives. One cycle later it fires a one-cycle laser pulse and clears its distance counter at the same time. From the next cycle it counts clock cycles until a return echo is sampled high. The counter then stops, and its value stays on the output as the measured range until the next start request.

The controller is a Moore machine with four states: idle, pulse, counting and finished. Every control output is decoded from the state alone. The distance counter sits inside the block so its result can be read directly. It saturates at all-ones, so an echo that arrives very late reports the maximum range rather than a wrapped value. Start requests are ignored while a measurement is running. Echoes are ignored unless the counter is running.

Top module: `tof_ranger`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after a clock edge with `rst` high, `ping`, `clear_count`, `enable_count` and `done` are all 0 and `distance` is 0.
- R2: If `start` is sampled high while the block is idle or finished, then in the next cycle `ping` and `clear_count` are both 1. Both are 1 for exactly that one cycle.
- R3: `enable_count` is 1 in every cycle from the cycle after the pulse up to and including the cycle in which `echo` is sampled high. It is 0 in all other cycles.
- R4: If `echo` is sampled high in the k-th cycle of `enable_count`, then from the next cycle `done` is 1 and `distance` equals k (below saturation).
- R5: `distance` never wraps. When more than 2^CNT_W-1 counting cycles pass, it stays at 2^CNT_W-1.
- R6: `echo` has no effect while the block is idle, pulsing or finished. No output changes because of it.
- R7: `start` has no effect while the block is pulsing or counting. No second pulse occurs and the result is unchanged.
- R8: `done` and `distance` hold until the next accepted `start`. That start begins a fresh measurement from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Measurement request |
| echo | input | 1 | Return pulse detected |
| ping | output | 1 | Fire laser pulse (one cycle) |
| clear_count | output | 1 | Distance counter is being cleared |
| enable_count | output | 1 | Distance counter is running |
| done | output | 1 | Result is valid and held |
| distance | output | CNT_W | Measured cycle count |

## Verification
The assertions check, on every cycle, the properties that hold locally: the pulse lasts one cycle, counting follows the pulse, the counter steps by one or holds at saturation, at most one phase output is high, and the result stays frozen while finished. Only the bench scenarios can show the end-to-end result of a whole measurement. They sweep the echo delay across and beyond the saturation point with a small counter width, and check that the final `distance` equals the delay, or the maximum once the delay passes it. The same scenarios also check that stray start and echo inputs in the wrong phases leave the result unchanged.

// File: rtl/tof_ranger.sv
module tof_ranger #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             echo,
  output logic             ping,
  output logic             clear_count,
  output logic             enable_count,
  output logic             done,
  output logic [CNT_W-1:0] distance
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_RUN, S_HOLD} state_t;
  state_t state, state_nx;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (start) state_nx = S_PULSE;
      S_PULSE: state_nx = S_RUN;
      S_RUN:   if (echo) state_nx = S_HOLD;
      S_HOLD:  if (start) state_nx = S_PULSE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  assign ping         = (state == S_PULSE);
  assign clear_count  = (state == S_PULSE);
  assign enable_count = (state == S_RUN);
  assign done         = (state == S_HOLD);

  always_ff @(posedge clk) begin
    if (rst || clear_count)            cnt <= '0;
    else if (enable_count && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign distance = cnt;

  p_ping_single_r2: assert property (@(posedge clk) disable iff (rst)
    ping |=> !ping);
  p_ping_clears_r2: assert property (@(posedge clk) disable iff (rst)
    ping |=> (distance == '0));
  p_run_after_ping_r3: assert property (@(posedge clk) disable iff (rst)
    ping |=> enable_count);
  p_echo_stops_r4: assert property (@(posedge clk) disable iff (rst)
    (enable_count && echo) |=> (done && !enable_count));
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (enable_count && distance != CNT_MAX) |=> (distance == $past(distance) + 1'b1));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (enable_count && distance == CNT_MAX) |=> (distance == CNT_MAX));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(distance)));
  p_phase_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ping, enable_count, done}));
endmodule

// File: tb/tof_ranger_bench.sv
module tof_ranger_bench;
  localparam int PERIOD = 10;
  localparam int W = 5;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst = 1, start = 0, echo = 0;
  logic ping, clear_count, enable_count, done;
  logic [W-1:0] distance;
  int checks = 0, fails = 0;
  bit finished = 0;

  tof_ranger #(.CNT_W(W)) u_tof_ranger (
    .clk(clk), .rst(rst), .start(start), .echo(echo), .ping(ping),
    .clear_count(clear_count), .enable_count(enable_count), .done(done),
    .distance(distance));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int d);
    int expd;
    expd = (d > MAXV) ? MAXV : d;
    start = 1;
    @(negedge clk);
    chk("R2 ping", ping, 1);
    chk("R2 clear", clear_count, 1);
    start = (d % 2 == 1);
    echo = (d % 2 == 0);
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      chk("R3 enable", enable_count, 1);
      chk("R7 no second ping", ping, 0);
      echo = (i == d);
    end
    @(negedge clk);
    start = 0; echo = 0;
    chk("R4 done", done, 1);
    chk("R3 enable off", enable_count, 0);
    chk("R4/R5 distance", distance, expd);
    echo = 1;
    @(negedge clk);
    @(negedge clk);
    echo = 0;
    chk("R6 echo in done", distance, expd);
    chk("R8 hold done", done, 1);
    chk("R6 no ping", ping, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 ping", ping, 0);
    chk("R1 clear", clear_count, 0);
    chk("R1 enable", enable_count, 0);
    chk("R1 done", done, 0);
    chk("R1 distance", distance, 0);
    echo = 1;
    repeat (2) @(negedge clk);
    echo = 0;
    chk("R6 echo in idle", enable_count | done | ping, 0);
    for (int d = 1; d <= MAXV + 6; d++) measure(d);
    measure(3);
    chk("R8 restart from zero", distance, 3);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 reset from done", done, 0);
    chk("R1 reset distance", distance, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule